// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the address for each beat of a four-beat burst. A load strobe captures a full address from outside; that address appears on the output one clock later and becomes the start of a new burst. Every clock in which the active-low advance input is asserted (and no load is present), the two least-significant address bits move to the next beat of the burst while the upper bits stay exactly as loaded. With neither strobe active the output holds.

The step order comes from an order-select input. Low selects a linear order: the low bits count up by one, modulo four, from the start value. High selects an interleaved order: each beat is the start value XORed with the beat number 0, 1, 2, 3. Interleaved is the intended strap value when the system leaves the selection at its default. After four advances the burst wraps back to its start address. The advance counts every beat the host launches, including beats whose data is later discarded, so the sequence never depends on anything except these strobes.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset is released (and its two-clock synchronising delay has elapsed), `addr_o` is all zeros.
- R2: When `load_i` is 1 at a clock edge, `addr_o` equals the `addr_i` sampled at that edge from the next cycle on, and the beat number restarts at 0.
- R3: With `order_i` = 0 at an advance edge, the new low two bits equal (start low bits + beat number) modulo 4, where the beat number has just been incremented modulo 4 (start 01 gives 10, 11, 00, 01).
- R4: With `order_i` = 1 at an advance edge, the new low two bits equal the start low bits XOR the new beat number (start 10 gives 11, 00, 01, 10).
- R5: Four advances after a load, `addr_o` is again the loaded address, in either order.
- R6: When `load_i` is 0 and `adv_n_i` is 1 at an edge, `addr_o` does not change, whatever `addr_i` and `order_i` do.
- R7: An advance never changes the address bits above bit 1.
- R8: When `load_i` is 1 and `adv_n_i` is 0 at the same edge, the load takes effect and no advance happens.
- R9: The beat number is kept across a change of `order_i` in mid-burst; each advance computes its low bits from the start value and the beat number using the `order_i` value at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Captures `addr_i` as a new burst start, active high |
| adv_n_i | input | 1 | Advances one beat, active low |
| order_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address, registered |

## Verification
The hardest state to reach from the ports is a burst whose order is switched between beats, since the low bits then depend on a beat number that is never visible directly; the stimulus loads a start, advances under one order, flips `order_i`, keeps advancing and waits out hold cycles in between, so a stale or reset beat count shows up as a wrong address. Load-versus-advance collisions are driven deliberately, and a long run of pseudo-random strobes, orders and start values is compared each clock against a behavioural model kept in integers.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } burst_op_e;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [LOW_W-1:0] beat_q_o,
  output logic [LOW_W-1:0] beat_nxt_o
);

  logic [LOW_W-1:0] beat_q;
  logic [LOW_W-1:0] beat_d;
  logic             beat_en;

  always_comb begin
    beat_en = clr_i | step_i;
    if (clr_i) begin
      beat_d = '0;
    end else begin
      beat_d = beat_q + LOW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign beat_q_o   = beat_q;
  assign beat_nxt_o = beat_q + LOW_W'(1);

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] start_i,
  input  logic [LOW_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [LOW_W-1:0] low_o
);

  logic [LOW_W-1:0] lin_low;
  logic [LOW_W-1:0] ilv_low;

  // interleaved: each bit flips independently by the matching beat bit
  for (genvar b = 0; b < LOW_W; b++) begin : g_ilv_bit
    assign ilv_low[b] = start_i[b] ^ beat_i[b];
  end

  // linear: modulo 2**LOW_W sum, carry out of the field discarded
  assign lin_low = start_i + beat_i;

  always_comb begin
    unique case (order_i)
      ORD_LINEAR:     low_o = lin_low;
      ORD_INTERLEAVE: low_o = ilv_low;
      default:        low_o = ilv_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int LOW_W = $clog2(BURST_LEN);
  localparam int HI_W  = ADDR_W - LOW_W;

  logic             rst_core_n;
  burst_op_e        op;
  logic [LOW_W-1:0] start_q;
  logic [LOW_W-1:0] start_d;
  logic             start_en;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic [LOW_W-1:0] beat_q;
  logic [LOW_W-1:0] beat_nxt;
  logic [LOW_W-1:0] step_low;
  burst_order_e     order_sel;

  burst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // load has priority over advance
  always_comb begin
    if (load_i) begin
      op = OP_LOAD;
    end else if (!adv_n_i) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;
    end
  end

  burst_beat_ctr #(.LOW_W(LOW_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr_i      (op == OP_LOAD),
    .step_i     (op == OP_STEP),
    .beat_q_o   (beat_q),
    .beat_nxt_o (beat_nxt)
  );

  assign order_sel = burst_order_e'(order_i);

  burst_order_map #(.LOW_W(LOW_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_nxt),
    .order_i (order_sel),
    .low_o   (step_low)
  );

  always_comb begin
    start_en = (op == OP_LOAD);
    start_d  = addr_i[LOW_W-1:0];
    addr_en  = (op != OP_HOLD);
    unique case (op)
      OP_LOAD: addr_d = addr_i;
      OP_STEP: addr_d = {addr_q[ADDR_W-1 -: HI_W], step_low};
      default: addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      start_q <= '0;
      addr_q  <= '0;
    end else begin
      if (start_en) begin
        start_q <= start_d;
      end
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              load_i,
  input logic              adv_n_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);

  localparam int LOW_W = $clog2(BURST_LEN);

  // set while every beat since the last load used linear order
  logic lin_run_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lin_run_q <= 1'b1;
    end else if (load_i) begin
      lin_run_q <= 1'b1;
    end else if (!adv_n_i && order_i) begin
      lin_run_q <= 1'b0;
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_i |=> addr_o == $past(addr_i));

  // R8
  load_beats_adv_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_i && !adv_n_i) |=> addr_o == $past(addr_i));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_i && adv_n_i) |=> $stable(addr_o));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_i && !adv_n_i) |=> addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_i && !adv_n_i && !order_i && lin_run_q) |=>
      addr_o[LOW_W-1:0] == LOW_W'($past(addr_o[LOW_W-1:0]) + LOW_W'(1)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W    (ADDR_W),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .load_i     (load_i),
  .adv_n_i    (adv_n_i),
  .order_i    (order_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  localparam int AW = 18;

  logic          clk;
  logic          rst_n;
  logic          load_i;
  logic          adv_n_i;
  logic          order_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] addr_o;

  int checks;
  int fails;

  // behavioural reference state
  int unsigned m_base;
  int          m_beat;
  int unsigned m_exp;

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .adv_n_i (adv_n_i),
    .order_i (order_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int unsigned exp);
    checks++;
    if (addr_o !== AW'(exp)) begin
      fails++;
      $display("FAIL %s: addr_o actual %h expected %h", tag, addr_o, AW'(exp));
    end
  endtask

  // drive at negedge, let one rising edge pass, compare at next negedge
  task automatic step(input bit ld, input bit advn, input bit ord,
                      input int unsigned a, input string tag);
    int lo;
    load_i  = ld;
    adv_n_i = advn;
    order_i = ord;
    addr_i  = AW'(a);
    @(posedge clk);
    if (ld) begin
      m_base = a & ((1 << AW) - 1);
      m_beat = 0;
      m_exp  = m_base;
    end else if (!advn) begin
      m_beat = (m_beat + 1) % 4;
      if (ord) lo = (m_base % 4) ^ m_beat;
      else     lo = ((m_base % 4) + m_beat) % 4;
      m_exp = (m_exp / 4) * 4 + lo;
    end
    @(negedge clk);
    check(tag, m_exp);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned lfsr;
    checks = 0; fails = 0;
    m_base = 0; m_beat = 0; m_exp = 0;
    rst_n = 1'b0; load_i = 1'b0; adv_n_i = 1'b1; order_i = 1'b1; addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset value", 0);

    // R3 linear from start 01, then wrap (R5)
    step(1, 1, 0, 32'h2_A5C5, "R2 load");
    step(0, 0, 0, 0, "R3 linear beat1");
    step(0, 0, 0, 0, "R3 linear beat2");
    step(0, 0, 0, 0, "R3 linear beat3");
    step(0, 0, 0, 0, "R5 linear wrap");
    check("R5 linear back at start", 32'h2_A5C5);

    // R4 interleaved from start 10, then wrap
    step(1, 1, 1, 32'h1_3346, "R2 load");
    step(0, 0, 1, 0, "R4 interleave beat1");
    check("R4 start10 beat1 is 11", 32'h1_3347);
    step(0, 0, 1, 0, "R4 interleave beat2");
    check("R4 start10 beat2 is 00", 32'h1_3344);
    step(0, 0, 1, 0, "R4 interleave beat3");
    step(0, 0, 1, 0, "R5 interleave wrap");
    check("R5 interleave back at start", 32'h1_3346);

    // R6 hold while addr_i and order_i wiggle
    step(0, 0, 1, 0, "R4 beat before hold");
    step(0, 1, 0, 32'h3_FFFF, "R6 hold");
    step(0, 1, 1, 32'h0_1234, "R6 hold");
    step(0, 1, 0, 32'h2_0000, "R6 hold");
    step(0, 0, 1, 0, "R6 resume after hold");

    // R7 upper bits with all-ones upper field
    step(1, 1, 0, 32'h3_FFFF, "R2 load");
    step(0, 0, 0, 0, "R7 upper kept at carry");
    check("R7 low 11 wraps to 00 with upper intact", 32'h3_FFFC);

    // R8 load and advance together
    step(1, 0, 1, 32'h0_0ABD, "R8 load beats advance");
    step(1, 0, 0, 32'h1_1112, "R8 load beats advance again");
    step(0, 0, 0, 0, "R8 beat restarts after load");
    check("R8 beat restarted", 32'h1_1113);

    // R9 order change mid burst keeps beat number
    step(1, 1, 1, 32'h0_0005, "R2 load");
    step(0, 0, 1, 0, "R9 interleave first");
    step(0, 1, 0, 0, "R9 idle");
    step(0, 0, 0, 0, "R9 linear second");
    check("R9 start01 beat2 linear is 11", 32'h0_0007);
    step(0, 0, 1, 0, "R9 interleave third");
    check("R9 start01 beat3 interleave is 10", 32'h0_0006);

    // mixed pseudo-random run
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[7:4] == 4'd0, lfsr[9] & lfsr[10], lfsr[12],
           (lfsr >> 13) & 32'h3_FFFF, "R3 R4 R6 R9 mixed");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule